// File: doc/BRIEF.md
# Two-Wire Memory Page Write Engine

This block is the write-side protocol engine of a two-wire serial memory slave that holds a 16 KiB byte array. A bit-level front end decodes the bus and hands it start and stop conditions and whole received bytes. For each byte, the engine answers with an acknowledge decision one cycle later. A write transaction is made of four parts: a device byte carrying a 7-bit address and a direction bit, a high word-address byte, a low word-address byte, and then any number of data bytes. The data bytes collect in a one-page staging buffer. The position inside that buffer advances with each byte and wraps around inside the page.

When a stop ends a transaction that delivered data, the engine starts a timed programming cycle. It first copies every staged byte into the array through a simple synchronous RAM write port. It then stays busy until a parameterised cycle count runs out. While busy, it refuses its device address. A master can therefore poll for completion by repeating the address until it is acknowledged. The read path and the non-volatile cells themselves are handled elsewhere.

Top module: `eeprom_page_writer`

## Requirements
- R1: A device byte is acknowledged only when bits 7..1 equal the DEV_ADDR parameter and bit 0 (direction) is 0. Any other device byte is refused. When the device byte is refused, every later byte of that transaction is also refused, and nothing is written.
- R2: When the device byte is accepted, the high address byte and the low address byte are both acknowledged. The word address is formed from bits 5..0 of the high byte followed by all 8 bits of the low byte. Bit 6 of the high byte has no effect. Of the resulting 14 bits, bits 13..6 pick the page and bits 5..0 pick the starting offset.
- R3: The offset advances by one after each accepted data byte. After offset 63 it goes back to offset 0 of the same page. A later byte therefore replaces an earlier byte at the same offset.
- R4: Nothing reaches the array before the closing stop. The commit writes each offset that received data exactly once, with the last value given to it, at address {page, offset}. It never writes more than 64 bytes.
- R5: A stop that arrives before any data byte was accepted starts no programming cycle. busy stays 0 and nothing is written.
- R6: After a stop that ends a transaction carrying data, busy goes to 1 on the next cycle. It stays 1 for exactly T_WR_CYC cycles.
- R7: While busy is 1, a device byte is refused whatever its direction bit.
- R8: A start that arrives while a transaction is in progress throws away every data byte staged so far. Those bytes are never written.
- R9: When bit 7 of the high address byte is 1, the target is not the array. Data bytes are refused and nothing is written.
- R10: After reset, busy, ack_vld and mem_we are 0.
- R11: ack_vld is 1 for exactly the one cycle after each received byte. ack then gives the decision for that byte, with 1 meaning acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | One-cycle pulse: start or repeated start decoded |
| ev_stop | input | 1 | One-cycle pulse: stop decoded |
| rx_vld | input | 1 | One-cycle pulse: a full byte has been received |
| rx_byte | input | 8 | The received byte, valid with rx_vld |
| ack_vld | output | 1 | Acknowledge decision valid (cycle after rx_vld) |
| ack | output | 1 | 1 = acknowledge the byte, 0 = refuse |
| busy | output | 1 | Internal programming cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array byte address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench starts one transaction at offset 62 so the offset wraps. A design that failed to wrap inside the page would write into the next page. It also sends 66 bytes in one transaction: a design that did not let later bytes replace earlier ones would commit more than 64 writes or keep stale values at offsets 0 and 1. It polls with both direction bits while busy and measures how long busy lasts, which catches a design that answers too early or has an off-by-one in the programming time. Stops that come with no data, repeated starts in the middle of a data stream, a flipped bit 6 and a set bit 7 in the high address byte all check that the design adds no writes and keeps no abandoned bytes.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_DATA,
    PH_SKIP
  } phase_t;

  // Device byte selects this slave for a write.
  function automatic logic dev_write_match(input logic [7:0] b, input logic [6:0] a);
    return (b[7:1] == a) && (b[0] == 1'b0);
  endfunction

  // High address byte points into the array when its top bit is clear.
  function automatic logic hits_array(input logic [7:0] hi);
    return ~hi[7];
  endfunction

  // Word address: high byte with its two top bits masked, then low byte.
  function automatic logic [15:0] join_word(input logic [7:0] hi, input logic [7:0] lo);
    return {2'b00, hi[5:0], lo};
  endfunction

endpackage

// File: rtl/eeprom_pw_phase.sv
module eeprom_pw_phase
  import eeprom_pw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int ADDR_W = 14,
  parameter int PAGE_W = 6,
  localparam int PGN_W = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  input  logic              busy,
  output logic              ack_vld,
  output logic              ack,
  output logic              buf_we,
  output logic [PAGE_W-1:0] ptr,
  output logic [PGN_W-1:0]  page,
  output logic              stop_in_data,
  output logic              dev_phase
);

  phase_t            ph_q;
  logic [7:0]        hi_q;
  logic [PAGE_W-1:0] ptr_q;
  logic [PGN_W-1:0]  page_q;
  logic              ackv_q, ack_q;
  logic [15:0]       word_w;
  logic              byte_evt;

  assign byte_evt = rx_vld && !ev_start && !ev_stop;
  assign word_w   = join_word(hi_q, rx_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      hi_q   <= '0;
      ptr_q  <= '0;
      page_q <= '0;
      ackv_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      ackv_q <= 1'b0;
      ack_q  <= 1'b0;
      if (ev_start) begin
        ph_q <= PH_DEV;
      end else if (ev_stop) begin
        ph_q <= PH_IDLE;
      end else if (rx_vld) begin
        ackv_q <= 1'b1;
        unique case (ph_q)
          PH_DEV: begin
            if (dev_write_match(rx_byte, DEV_ADDR) && !busy) begin
              ack_q <= 1'b1;
              ph_q  <= PH_AHI;
            end else begin
              ph_q <= PH_SKIP;
            end
          end
          PH_AHI: begin
            ack_q <= 1'b1;
            hi_q  <= rx_byte;
            ph_q  <= PH_ALO;
          end
          PH_ALO: begin
            ack_q  <= 1'b1;
            ptr_q  <= word_w[PAGE_W-1:0];
            page_q <= word_w[ADDR_W-1:PAGE_W];
            ph_q   <= PH_DATA;
          end
          PH_DATA: begin
            if (hits_array(hi_q)) begin
              ack_q <= 1'b1;
              ptr_q <= ptr_q + 1'b1;
            end else begin
              ph_q <= PH_SKIP;
            end
          end
          default: ph_q <= ph_q;
        endcase
      end
    end
  end

  assign ack_vld      = ackv_q;
  assign ack          = ack_q;
  assign buf_we       = byte_evt && (ph_q == PH_DATA) && hits_array(hi_q);
  assign ptr          = ptr_q;
  assign page         = page_q;
  assign stop_in_data = ev_stop && !ev_start && (ph_q == PH_DATA);
  assign dev_phase    = (ph_q == PH_DEV);

endmodule

// File: rtl/eeprom_pw_pagebuf.sv
module eeprom_pw_pagebuf #(
  parameter int PAGE_W = 6,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [PAGE_W-1:0]     wr_off,
  input  logic [7:0]            wdata,
  input  logic                  clr,
  input  logic [PAGE_W-1:0]     rd_off,
  output logic [7:0]            rdata,
  output logic [PAGE_BYTES-1:0] filled
);

  logic [PAGE_BYTES-1:0][7:0] data_q;
  logic [PAGE_BYTES-1:0]      fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (clr) begin
      fill_q <= '0;
    end else if (we) begin
      fill_q[wr_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we && !clr) data_q[wr_off] <= wdata;
  end

  assign rdata  = data_q[rd_off];
  assign filled = fill_q;

endmodule

// File: rtl/eeprom_pw_prog.sv
module eeprom_pw_prog #(
  parameter int ADDR_W   = 14,
  parameter int PAGE_W   = 6,
  parameter int T_WR_CYC = 100,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PGN_W = ADDR_W - PAGE_W,
  localparam int CNT_W = $clog2(T_WR_CYC + PAGE_BYTES) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  launch,
  input  logic [PAGE_BYTES-1:0] fill_in,
  input  logic [PGN_W-1:0]      page_in,
  input  logic [7:0]            rd_data,
  output logic [PAGE_W-1:0]     rd_off,
  output logic                  busy,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [7:0]            mem_wdata
);

  logic                  busy_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [PAGE_BYTES-1:0] pend_q;
  logic [PGN_W-1:0]      page_q;
  logic                  in_walk;
  logic [PAGE_W-1:0]     idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pend_q <= '0;
      page_q <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      pend_q <= fill_in;
      page_q <= page_in;
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(T_WR_CYC - 1)) busy_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idx       = cnt_q[PAGE_W-1:0];
  assign in_walk   = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
  assign rd_off    = idx;
  assign busy      = busy_q;
  assign mem_we    = in_walk && pend_q[idx];
  assign mem_addr  = {page_q, idx};
  assign mem_wdata = rd_data;

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import eeprom_pw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int ADDR_W   = 14,
  parameter int PAGE_W   = 6,
  parameter int T_WR_CYC = 100,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int PGN_W = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  output logic              ack_vld,
  output logic              ack,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  logic                  buf_we_w;
  logic [PAGE_W-1:0]     ptr_w;
  logic [PGN_W-1:0]      page_w;
  logic                  stop_in_data_w;
  logic                  dev_phase_w;
  logic [PAGE_BYTES-1:0] filled_w;
  logic [7:0]            buf_rdata_w;
  logic [PAGE_W-1:0]     rd_off_w;
  logic                  launch_w;
  logic                  buf_clr_w;

  assign launch_w  = stop_in_data_w && (|filled_w) && !busy;
  assign buf_clr_w = ev_start || ev_stop;

  eeprom_pw_phase #(
    .DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)
  ) phase_i (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .busy(busy),
    .ack_vld(ack_vld), .ack(ack),
    .buf_we(buf_we_w), .ptr(ptr_w), .page(page_w),
    .stop_in_data(stop_in_data_w), .dev_phase(dev_phase_w)
  );

  eeprom_pw_pagebuf #(.PAGE_W(PAGE_W)) buf_i (
    .clk(clk), .rst_n(rst_n),
    .we(buf_we_w), .wr_off(ptr_w), .wdata(rx_byte),
    .clr(buf_clr_w), .rd_off(rd_off_w),
    .rdata(buf_rdata_w), .filled(filled_w)
  );

  eeprom_pw_prog #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .T_WR_CYC(T_WR_CYC)
  ) prog_i (
    .clk(clk), .rst_n(rst_n),
    .launch(launch_w), .fill_in(filled_w), .page_in(page_w),
    .rd_data(buf_rdata_w), .rd_off(rd_off_w),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

endmodule

// File: rtl/eeprom_pw_chk.sv
module eeprom_pw_chk #(
  parameter int PAGE_W   = 6,
  parameter int T_WR_CYC = 100,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              rx_vld,
  input logic              ack_vld,
  input logic              ack,
  input logic              busy,
  input logic              mem_we,
  input logic              launch,
  input logic              buf_we,
  input logic              dev_phase,
  input logic [PAGE_W-1:0] ptr
);

  int unsigned run_len;
  int unsigned we_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len <= 0;
      we_cnt  <= 0;
    end else begin
      if (launch) run_len <= 0;
      else if (busy) run_len <= run_len + 1;
      if (launch) we_cnt <= 0;
      else if (mem_we) we_cnt <= we_cnt + 1;
    end
  end

  a_r6_busy_follows_launch: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  a_r5_busy_needs_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));

  a_r6_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == T_WR_CYC));

  a_r4_write_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r4_write_cap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (we_cnt < PAGE_BYTES));

  a_r7_refuse_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_vld && dev_phase && busy && !ev_start && !ev_stop) |=> (ack_vld && !ack));

  a_r3_offset_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && (ptr == '1)) |=> (ptr == '0));

  a_r11_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(rx_vld));

endmodule

bind eeprom_page_writer eeprom_pw_chk #(
  .PAGE_W(PAGE_W), .T_WR_CYC(T_WR_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
  .rx_vld(rx_vld), .ack_vld(ack_vld), .ack(ack), .busy(busy),
  .mem_we(mem_we), .launch(launch_w), .buf_we(buf_we_w),
  .dev_phase(dev_phase_w), .ptr(ptr_w)
);

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb_top;

  localparam int T_WR = 100;
  localparam logic [7:0] DEV_W = 8'hA0;
  localparam logic [7:0] DEV_R = 8'hA1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 1'b0, ev_stop = 1'b0, rx_vld = 1'b0;
  logic [7:0] rx_byte = '0;
  logic ack_vld, ack, busy, mem_we;
  logic [13:0] mem_addr;
  logic [7:0] mem_wdata;

  int n_chk = 0, n_bad = 0;

  logic [13:0] log_addr [128];
  logic [7:0]  log_data [128];
  int          log_n = 0;

  logic [7:0] exp_val [64];
  bit         exp_set [64];

  always #4 clk = ~clk;

  eeprom_page_writer #(.DEV_ADDR(7'h50), .T_WR_CYC(T_WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .ack_vld(ack_vld), .ack(ack),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (log_n < 128) begin
        log_addr[log_n] = mem_addr;
        log_data[log_n] = mem_wdata;
      end
      log_n = log_n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) ev_start = 1'b1;
    @(negedge clk) ev_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) ev_stop = 1'b1;
    @(negedge clk) ev_stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output bit acked);
    @(negedge clk);
    rx_vld = 1'b1;
    rx_byte = b;
    @(negedge clk);
    rx_vld = 1'b0;
    check("R11 ack_vld after byte", int'(ack_vld), 1);
    acked = ack_vld && ack;
    @(negedge clk);
    check("R11 ack_vld single cycle", int'(ack_vld), 0);
  endtask

  task automatic busy_len(output int len);
    len = 0;
    while (busy && len < 10000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic clear_model();
    log_n = 0;
    for (int i = 0; i < 64; i++) begin
      exp_set[i] = 1'b0;
      exp_val[i] = '0;
    end
  endtask

  // Compare the write log with the page model (R4).
  task automatic check_log(input string req, input logic [7:0] page);
    int want = 0;
    for (int i = 0; i < 64; i++) if (exp_set[i]) want++;
    check({req, " write count"}, log_n, want);
    for (int i = 0; i < log_n && i < 128; i++) begin
      int off = int'(log_addr[i][5:0]);
      check({req, " page"}, int'(log_addr[i][13:6]), int'(page));
      check({req, " offset expected"}, int'(exp_set[off]), 1);
      check({req, " data"}, int'(log_data[i]), int'(exp_val[off]));
    end
  endtask

  // Full write transaction: device, two address bytes, n data bytes, stop.
  task automatic page_write(input string req, input logic [7:0] hi, input logic [7:0] lo,
                            input int n, input logic [7:0] seed);
    bit a;
    int len;
    int off;
    logic [7:0] page;
    page = {hi[5:0], lo[7:6]};
    off = int'(lo[5:0]);
    clear_model();
    pulse_start();
    send(DEV_W, a); check({req, " R1 device ack"}, int'(a), 1);
    send(hi, a);    check({req, " R2 high address ack"}, int'(a), 1);
    send(lo, a);    check({req, " R2 low address ack"}, int'(a), 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = seed + 8'(i);
      send(d, a);
      check({req, " R2 data ack"}, int'(a), 1);
      exp_val[off] = d;
      exp_set[off] = 1'b1;
      off = (off + 1) % 64;
    end
    check({req, " R4 no write before stop"}, log_n, 0);
    pulse_stop();
    busy_len(len);
    check({req, " R6 busy length"}, len, T_WR);
    check_log(req, page);
  endtask

  task automatic t_reset();
    check("R10 busy after reset", int'(busy), 0);
    check("R10 ack_vld after reset", int'(ack_vld), 0);
    check("R10 mem_we after reset", int'(mem_we), 0);
  endtask

  task automatic t_basic();
    page_write("basic", 8'h01, 8'h23, 3, 8'h10);
    // Bit 6 of the high byte has no effect on the address (R2).
    page_write("R2 bit6 ignored", 8'h41, 8'h23, 2, 8'h77);
  endtask

  task automatic t_wrap();
    page_write("R3 wrap from 62", 8'h2A, 8'hBE, 5, 8'h30);
    page_write("R3 overwrite 66", 8'h3F, 8'hC0, 66, 8'h80);
    check("R3 offset0 overwritten", int'(exp_val[0]), 8'hC0);
  endtask

  task automatic t_poll();
    bit a;
    int len;
    clear_model();
    pulse_start();
    send(DEV_W, a); send(8'h00, a); send(8'h05, a); send(8'h5A, a);
    pulse_stop();
    check("R6 busy right after stop", int'(busy), 1);
    pulse_start();
    send(DEV_W, a); check("R7 write address refused while busy", int'(a), 0);
    send(8'h00, a); check("R7 later byte refused while busy", int'(a), 0);
    pulse_start();
    send(DEV_R, a); check("R7 read address refused while busy", int'(a), 0);
    pulse_stop();
    busy_len(len);
    check("R7 polling did not extend busy", int'(busy), 0);
    check("R7 single write committed", log_n, 1);
    pulse_start();
    send(DEV_W, a); check("R7 address accepted after busy", int'(a), 1);
    pulse_stop();
  endtask

  task automatic t_wrong_addr();
    bit a;
    clear_model();
    pulse_start();
    send(8'hA2, a); check("R1 other device refused", int'(a), 0);
    send(8'h00, a); check("R1 following byte refused", int'(a), 0);
    send(8'h00, a); send(8'h11, a);
    check("R1 data refused", int'(a), 0);
    pulse_stop();
    check("R1 no busy", int'(busy), 0);
    pulse_start();
    send(DEV_R, a); check("R1 read direction refused", int'(a), 0);
    pulse_stop();
    repeat (3) @(negedge clk);
    check("R1 nothing written", log_n, 0);
  endtask

  task automatic t_empty_stop();
    bit a;
    clear_model();
    pulse_start();
    send(DEV_W, a); send(8'h02, a); send(8'h00, a);
    pulse_stop();
    check("R5 no busy on empty stop", int'(busy), 0);
    repeat (3) @(negedge clk);
    check("R5 nothing written", log_n, 0);
  endtask

  task automatic t_restart();
    bit a;
    clear_model();
    pulse_start();
    send(DEV_W, a); send(8'h03, a); send(8'h00, a);
    send(8'hDE, a); send(8'hAD, a);
    pulse_start();
    pulse_stop();
    check("R8 abandoned bytes start no cycle", int'(busy), 0);
    repeat (3) @(negedge clk);
    check("R8 abandoned bytes not written", log_n, 0);
    page_write("R8 fresh after restart", 8'h03, 8'h10, 1, 8'h44);
  endtask

  task automatic t_upper();
    bit a;
    clear_model();
    pulse_start();
    send(DEV_W, a); send(8'h80, a); send(8'h00, a);
    send(8'h99, a); check("R9 data refused outside array", int'(a), 0);
    pulse_stop();
    check("R9 no busy", int'(busy), 0);
    repeat (3) @(negedge clk);
    check("R9 nothing written", log_n, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_poll();
    t_wrong_addr();
    t_empty_stop();
    t_restart();
    t_upper();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule